// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block collects up to 32 interrupt sources into one status bank that software reaches through a small word-addressed register bus. Every source owns one fixed bit index, and that index means the same source in every register of the bank. A source pulse latches a cause bit. Software can also raise any cause bit itself. Software removes a pending cause in one of two ways, chosen bit by bit: by writing a 1 to it, or by reading it. A separate mask hides causes from the single interrupt line. The mask can be written whole, or its bits can be set or cleared one at a time through dedicated write-one ports.

The register bus has no back-pressure. An access is accepted in every cycle where its strobe is high. Read data is combinational from the address and shows the bank state before the clock edge that ends the access. Side effects of a read or write take effect on that edge. The interrupt output comes from a flop, so it has no combinational path from any input.

Top module: `icb_bank`

## Requirements
- R1: After reset every cause bit is 0, every clear-mode bit is 0, every mask bit is 1, and the interrupt output is 0.
- R2: Word offsets are fixed as follows: 0 is clear-mode, 1 is cause, 2 is masked cause, 3 is cause-set, 4 is mask, 5 is mask-set, 6 is mask-clear. Offset 7 reads as zero, and writes to it change nothing.
- R3: When a cause bit's clear-mode bit is 0, writing 1 to that bit at offset 1 clears it, and writing 0 leaves it unchanged.
- R4: When a cause bit's clear-mode bit is 1, a read of offset 1 returns the bit and then clears it at the end of that cycle. Writing 1 to the bit has no effect.
- R5: Offset 2 reads as cause AND NOT mask. Reads and writes at offset 2 clear cause bits under the same per-bit rule as offset 1.
- R6: Writing 1 to a bit at offset 3 sets that cause bit. Offset 3 reads as zero.
- R7: Offset 4 reads back the mask, and a write to it replaces the whole mask.
- R8: Writing 1 at offset 5 sets that mask bit, and writing 1 at offset 6 clears it. Zero bits leave the mask unchanged, and both offsets read as zero.
- R9: A source pulse sets its cause bit on the next edge. If a set and a clear of the same bit fall in one cycle, the bit ends up set.
- R10: After every clock edge the interrupt output equals the OR of cause AND NOT mask held in the bank, and it comes from a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Word offset inside the bank |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, accepted every cycle |
| bus_re | input | 1 | Read strobe, accepted every cycle |
| bus_rdata | output | 32 | Read data for the current address |
| src_pulse | input | 32 | Hardware cause set, one bit per source |
| irq_o | output | 1 | Aggregated interrupt request |

## Verification
The bench exercises both clear disciplines on neighbouring bits within the same write. In one case a write of 1 removes a write-clear bit and leaves a read-clear bit in place, which separates the two modes. Clearing through the masked view is tried with reads and with writes. Set-versus-clear collisions are tried both with a write clear and with a read clear. Mask updates through the whole-word, set and clear ports are each followed by a read-back and by a check of the interrupt line, which shows that masking alone can raise or drop the line while the causes stay the same.

// File: rtl/icb_pkg.sv
package icb_pkg;

  typedef enum logic [2:0] {
    OFS_MODE   = 3'd0,
    OFS_CAUSE  = 3'd1,
    OFS_MASKED = 3'd2,
    OFS_SET    = 3'd3,
    OFS_MASK   = 3'd4,
    OFS_MSET   = 3'd5,
    OFS_MCLR   = 3'd6
  } icb_ofs_e;

  typedef struct packed {
    logic wr_mode;
    logic wr_cause;   // write to cause or masked-cause view
    logic rd_cause;   // read of cause or masked-cause view
    logic wr_set;
    logic wr_mask;
    logic wr_mset;
    logic wr_mclr;
  } icb_stb_t;

endpackage

// File: rtl/icb_decode.sv
module icb_decode
  import icb_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  output icb_stb_t          stb_o
);

  function automatic logic hit(input logic [ADDR_W-1:0] a, input icb_ofs_e o);
    return a == ADDR_W'(o);
  endfunction

  always_comb begin
    stb_o          = '0;
    stb_o.wr_mode  = we_i && hit(addr_i, OFS_MODE);
    stb_o.wr_cause = we_i && (hit(addr_i, OFS_CAUSE) || hit(addr_i, OFS_MASKED));
    stb_o.rd_cause = re_i && (hit(addr_i, OFS_CAUSE) || hit(addr_i, OFS_MASKED));
    stb_o.wr_set   = we_i && hit(addr_i, OFS_SET);
    stb_o.wr_mask  = we_i && hit(addr_i, OFS_MASK);
    stb_o.wr_mset  = we_i && hit(addr_i, OFS_MSET);
    stb_o.wr_mclr  = we_i && hit(addr_i, OFS_MCLR);
  end

endmodule

// File: rtl/icb_cause_bit.sv
module icb_cause_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_wr_i,   // clear-mode register write
  input  logic mode_d_i,    // write data bit for clear-mode
  input  logic w1c_i,       // write of 1 to cause / masked view
  input  logic rd_i,        // read of cause / masked view
  input  logic set_i,       // hardware or software set
  output logic mode_o,
  output logic q_o,
  output logic d_o
);

  logic mode_q, q;
  logic clr;

  // 0: write-one clears, 1: read clears
  assign clr = mode_q ? rd_i : w1c_i;
  assign d_o = set_i | (q & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      q      <= 1'b0;
    end else begin
      if (mode_wr_i) mode_q <= mode_d_i;
      q <= d_o;
    end
  end

  assign mode_o = mode_q;
  assign q_o    = q;

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_o && w1c_i && !set_i) |=> !q_o);
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o && rd_i && !set_i) |=> !q_o);
  a_r4_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o && !rd_i && !set_i) |=> (q_o == $past(q_o)));

endmodule

// File: rtl/icb_mask.sv
module icb_mask #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] mask_o,
  output logic [N-1:0] nxt_o
);

  logic [N-1:0] mask_q;

  always_comb begin
    nxt_o = mask_q;
    if (wr_i)  nxt_o = wdata_i;
    if (set_i) nxt_o = mask_q | wdata_i;
    if (clr_i) nxt_o = mask_q & ~wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '1;
    else        mask_q <= nxt_o;
  end

  assign mask_o = mask_q;

  a_r7_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (mask_o == $past(wdata_i)));
  a_r8_set_port: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> ((mask_o & $past(wdata_i)) == $past(wdata_i)));
  a_r8_clr_port: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> ((mask_o & $past(wdata_i)) == '0));
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && !set_i && !clr_i) |=> $stable(mask_o));

endmodule

// File: rtl/icb_readmux.sv
module icb_readmux
  import icb_pkg::*;
#(
  parameter int N      = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      mode_i,
  input  logic [N-1:0]      cause_i,
  input  logic [N-1:0]      mask_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [N-1:0] sel;

  always_comb begin
    sel = '0;
    if      (addr_i == ADDR_W'(OFS_MODE))   sel = mode_i;
    else if (addr_i == ADDR_W'(OFS_CAUSE))  sel = cause_i;
    else if (addr_i == ADDR_W'(OFS_MASKED)) sel = cause_i & ~mask_i;
    else if (addr_i == ADDR_W'(OFS_MASK))   sel = mask_i;
  end

  assign rdata_o = DATA_W'(sel);

  a_r6_set_port_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == ADDR_W'(OFS_SET)) |-> (rdata_o == '0));
  a_r8_mask_ports_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr_i == ADDR_W'(OFS_MSET)) || (addr_i == ADDR_W'(OFS_MCLR))) |-> (rdata_o == '0));

endmodule

// File: rtl/icb_bank.sv
module icb_bank
  import icb_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_SRC-1:0]  src_pulse,
  output logic              irq_o
);

  localparam int W = N_SRC;

  icb_stb_t     stb;
  logic [W-1:0] wd;
  logic [W-1:0] mode, cause, cause_d, mask, mask_d;
  logic         irq_q;

  assign wd = bus_wdata[W-1:0];

  icb_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (bus_addr),
    .we_i   (bus_we),
    .re_i   (bus_re),
    .stb_o  (stb)
  );

  for (genvar i = 0; i < W; i++) begin : g_bit
    icb_cause_bit u_bit (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_wr_i (stb.wr_mode),
      .mode_d_i  (wd[i]),
      .w1c_i     (stb.wr_cause && wd[i]),
      .rd_i      (stb.rd_cause),
      .set_i     (src_pulse[i] || (stb.wr_set && wd[i])),
      .mode_o    (mode[i]),
      .q_o       (cause[i]),
      .d_o       (cause_d[i])
    );
  end

  icb_mask #(.N(W)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (stb.wr_mask),
    .set_i   (stb.wr_mset),
    .clr_i   (stb.wr_mclr),
    .wdata_i (wd),
    .mask_o  (mask),
    .nxt_o   (mask_d)
  );

  icb_readmux #(.N(W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_i  (bus_addr),
    .mode_i  (mode),
    .cause_i (cause),
    .mask_i  (mask),
    .rdata_o (bus_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(cause_d & ~mask_d);
  end

  assign irq_o = irq_q;

  a_r10_irq_tracks_bank: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == |(cause & ~mask));
  a_r9_source_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (src_pulse != '0) |=> ((cause & $past(src_pulse)) == $past(src_pulse)));

endmodule

// File: tb/sim_icb_bank.sv
module sim_icb_bank;

  typedef struct packed {
    logic        we;
    logic        re;
    logic [2:0]  addr;
    logic [31:0] wdata;
    logic [31:0] src;
    logic [31:0] erd;
    logic        eirq;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b1,3'd4,32'h0,32'h0,32'hFFFF_FFFF,1'b0,8'd1},   // R1 mask all ones
    '{1'b0,1'b1,3'd0,32'h0,32'h0,32'h0,1'b0,8'd1},           // R1 mode zero
    '{1'b0,1'b1,3'd1,32'h0,32'h0,32'h0,1'b0,8'd1},           // R1 cause zero
    '{1'b1,1'b0,3'd3,32'hF0,32'h0,32'h0,1'b0,8'd6},          // R6 sw set, masked
    '{1'b0,1'b1,3'd1,32'h0,32'h0,32'hF0,1'b0,8'd6},          // R6
    '{1'b0,1'b1,3'd3,32'h0,32'h0,32'h0,1'b0,8'd6},           // R6 reads zero
    '{1'b0,1'b1,3'd2,32'h0,32'h0,32'h0,1'b0,8'd5},           // R5 all masked
    '{1'b1,1'b0,3'd6,32'h30,32'h0,32'h0,1'b1,8'd8},          // R8 mask clear
    '{1'b0,1'b1,3'd4,32'h0,32'h0,32'hFFFF_FFCF,1'b1,8'd8},   // R8
    '{1'b0,1'b1,3'd2,32'h0,32'h0,32'h30,1'b1,8'd5},          // R5 view
    '{1'b0,1'b1,3'd5,32'h0,32'h0,32'h0,1'b1,8'd8},           // R8 reads zero
    '{1'b1,1'b0,3'd1,32'h10,32'h0,32'h0,1'b1,8'd3},          // R3 w1c
    '{1'b1,1'b0,3'd2,32'h20,32'h0,32'h0,1'b0,8'd5},          // R5 clear via view
    '{1'b0,1'b1,3'd1,32'h0,32'h0,32'hC0,1'b0,8'd3},          // R3
    '{1'b1,1'b0,3'd4,32'hFFFF_F000,32'h0,32'h0,1'b1,8'd7},   // R7 direct write
    '{1'b0,1'b1,3'd4,32'h0,32'h0,32'hFFFF_F000,1'b1,8'd7},   // R7
    '{1'b1,1'b0,3'd0,32'h80,32'h0,32'h0,1'b1,8'd4},          // R4 bit7 read-clear
    '{1'b0,1'b1,3'd0,32'h0,32'h0,32'h80,1'b1,8'd4},          // R4
    '{1'b1,1'b0,3'd1,32'hC0,32'h0,32'h0,1'b1,8'd4},          // R4 write ignored on bit7
    '{1'b0,1'b1,3'd1,32'h0,32'h0,32'h80,1'b0,8'd4},          // R4 read then clear
    '{1'b0,1'b1,3'd1,32'h0,32'h0,32'h0,1'b0,8'd4},           // R4
    '{1'b0,1'b0,3'd0,32'h0,32'h100,32'h0,1'b1,8'd9},         // R9 source pulse
    '{1'b1,1'b0,3'd5,32'h100,32'h0,32'h0,1'b0,8'd8},         // R8 mask set
    '{1'b0,1'b1,3'd2,32'h0,32'h0,32'h0,1'b0,8'd5},           // R5
    '{1'b0,1'b1,3'd1,32'h0,32'h0,32'h100,1'b0,8'd9},         // R9
    '{1'b1,1'b0,3'd1,32'h100,32'h100,32'h0,1'b0,8'd9},       // R9 set beats w1c
    '{1'b0,1'b1,3'd1,32'h0,32'h0,32'h100,1'b0,8'd9},         // R9
    '{1'b1,1'b0,3'd0,32'h200,32'h0,32'h0,1'b0,8'd4},         // R4 bit9 read-clear
    '{1'b0,1'b0,3'd0,32'h0,32'h200,32'h0,1'b1,8'd10},        // R10 unmasked raise
    '{1'b0,1'b1,3'd2,32'h0,32'h0,32'h200,1'b0,8'd5},         // R5 view read clears
    '{1'b0,1'b1,3'd1,32'h0,32'h0,32'h100,1'b0,8'd5},         // R5
    '{1'b0,1'b1,3'd1,32'h0,32'h200,32'h100,1'b1,8'd9},       // R9 set beats read clear
    '{1'b0,1'b1,3'd7,32'h0,32'h0,32'h0,1'b1,8'd2},           // R2 hole reads zero
    '{1'b1,1'b0,3'd7,32'hFFFF_FFFF,32'h0,32'h0,1'b1,8'd2},   // R2 hole write
    '{1'b0,1'b1,3'd4,32'h0,32'h0,32'hFFFF_F100,1'b1,8'd2},   // R2 mask untouched
    '{1'b0,1'b1,3'd1,32'h0,32'h0,32'h300,1'b0,8'd2}          // R2 cause untouched
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] src_pulse = '0;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  icb_bank u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .src_pulse (src_pulse),
    .irq_o     (irq_o)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input vec_t v);
    @(negedge clk);
    bus_we    = v.we;
    bus_re    = v.re;
    bus_addr  = v.addr;
    bus_wdata = v.wdata;
    src_pulse = v.src;
    #2;
    if (v.re) check(bus_rdata, v.erd, int'(v.req), "read data");
    @(posedge clk);
    #2;
    check({31'b0, irq_o}, {31'b0, v.eirq}, int'(v.req), "irq");
    bus_we    = 1'b0;
    bus_re    = 1'b0;
    src_pulse = '0;
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check({31'b0, irq_o}, 32'h0, 1, "irq in reset");  // R1
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) step(TBL[k]);

    // R1 directed: reset in the middle of activity restores defaults
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    check({31'b0, irq_o}, 32'h0, 1, "irq after mid reset");
    bus_addr = 3'd4;
    #1;
    check(bus_rdata, 32'hFFFF_FFFF, 1, "mask after mid reset");
    bus_addr = 3'd1;
    #1;
    check(bus_rdata, 32'h0, 1, "cause after mid reset");
    bus_addr = 3'd0;
    #1;
    check(bus_rdata, 32'h0, 1, "mode after mid reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R10 directed: masking alone drops and raises the line
    step('{1'b0,1'b0,3'd0,32'h0,32'h1,32'h0,1'b0,8'd10});
    step('{1'b1,1'b0,3'd6,32'h1,32'h0,32'h0,1'b1,8'd10});
    step('{1'b1,1'b0,3'd5,32'h1,32'h0,32'h0,1'b0,8'd10});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule